// File: doc/BRIEF.md
# Three-Source Interrupt Controller with Overflow Pool Registers

This block collects interrupt events from a graphics-style engine and presents them on a single interrupt line. Two of its sources are completion events, one for the tiling pass (flush done) and one for the frame render pass (frame done). Each completion source arrives as a one-cycle pulse and is held in a status bit until software acknowledges it. The third source is an out-of-memory condition. It is a level, not a pulse: it stays high while the tiler needs overflow memory and no pool has been supplied. Because it follows a level, acknowledging its status bit has no lasting effect while the cause remains.

Software sees five word registers on a simple single-cycle bus:
- A status register, cleared by writing 1s.
- An enable-set register and an enable-clear register. Both read back the same enable mask.
- An overflow pool base register.
- An overflow pool size register.

Writing a nonzero pool size resolves the out-of-memory condition. A consume pulse from the tiler returns the size to zero, which means the pool has been used up. The interrupt output is a registered OR of all pending bits that are also enabled.

Top module: `gfx_irq_ctrl`

## Requirements
- R1: After a synchronous reset, the status register, the enable mask, the interrupt output, the pool base and the pool size are all zero.
- R2: The status bit positions are: bit 0 is flush done, bit 1 is frame done, bit 2 is out of memory. A one-cycle pulse on `flush_done` or `frame_done` sets its bit at that clock edge. The bit holds until it is acknowledged. Status reads at byte offset 0x0.
- R3: Writing to offset 0x0 clears each status bit whose write-data bit is 1. Status bits written with 0 keep their value.
- R4: If a completion pulse and a write-1 clear hit the same status bit in the same cycle, the bit stays set.
- R5: Writing to offset 0x4 sets each enable-mask bit whose write-data bit is 1. Bits written with 0 are left unchanged.
- R6: Writing to offset 0x8 clears each enable-mask bit whose write-data bit is 1. Bits written with 0 are left unchanged.
- R7: Reading offset 0x4 returns the enable mask in bits 2:0. Reading offset 0x8 returns the same mask. All upper bits read as zero.
- R8: `irq` is a register that equals the OR of (status AND mask) as it stood one clock earlier.
- R9: While `mem_req` is high and the pool size is zero, the out-of-memory condition is active. An active condition sets status bit 2 one cycle later. Status bit 2 cannot be cleared while the condition stays active.
- R10: Writing a nonzero value to the pool size at offset 0x10 ends the condition at that edge. Offset 0xC holds the pool base. Both registers read back and drive the `pool_base` and `pool_size` outputs. After the size write, acknowledging bit 2 clears it, and re-enabling the source leaves `irq` low.
- R11: A `pool_consume` pulse returns the pool size to zero. If `mem_req` is still high, the condition becomes active again and status bit 2 sets again.
- R12: Read data appears on `bus_rdata` in the cycle after a read access. Offsets outside the five registers read as zero. Writes to those offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (5) | Byte offset of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, registered |
| flush_done | input | 1 | Tiling pass finished pulse |
| frame_done | input | 1 | Frame render finished pulse |
| mem_req | input | 1 | Tiler requests overflow memory (level) |
| pool_consume | input | 1 | Tiler has used up the current pool (pulse) |
| pool_base | output | POOL_AW (32) | Overflow pool base address |
| pool_size | output | POOL_SW (32) | Overflow pool size, zero means none |
| irq | output | 1 | Interrupt request, registered |

## Verification
Suppose a pending bit latched wrongly or was lost. That shows up at `irq` exactly one cycle after the edge where status changed, provided the source is enabled. It also shows up on the next status read.

Suppose the enable mask was corrupted. The corruption appears in both mask read-backs. It also makes `irq` either stay low for a pending bit or rise with nothing enabled.

A pool size or condition register that does not clear would keep status bit 2 set through an acknowledge. The next status read would then return 4 where 0 is expected. A stale condition after a consume pulse shows up in the same way within two cycles.

// File: rtl/gfx_irq_pkg.sv
package gfx_irq_pkg;
  localparam int SRC_N     = 3;
  localparam int SRC_FLUSH = 0;
  localparam int SRC_FRAME = 1;
  localparam int SRC_OOM   = 2;

  typedef enum logic [2:0] {
    RSEL_STATUS = 3'd0,
    RSEL_EN_SET = 3'd1,
    RSEL_EN_CLR = 3'd2,
    RSEL_BASE   = 3'd3,
    RSEL_SIZE   = 3'd4,
    RSEL_NONE   = 3'd7
  } rsel_e;

  typedef struct packed {
    logic status;
    logic en_set;
    logic en_clr;
    logic base;
    logic size;
  } wr_hit_t;
endpackage

// File: rtl/gfx_irq_decode.sv
module gfx_irq_decode
  import gfx_irq_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  output wr_hit_t           wr_hit,
  output logic              rd_en,
  output rsel_e             rd_sel
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] word_idx;
  rsel_e            sel;

  assign word_idx = bus_addr[ADDR_W-1:2];

  always_comb begin
    case (word_idx)
      IDX_W'(0): sel = RSEL_STATUS;
      IDX_W'(1): sel = RSEL_EN_SET;
      IDX_W'(2): sel = RSEL_EN_CLR;
      IDX_W'(3): sel = RSEL_BASE;
      IDX_W'(4): sel = RSEL_SIZE;
      default:   sel = RSEL_NONE;
    endcase
  end

  always_comb begin
    wr_hit        = '0;
    wr_hit.status = bus_sel && bus_we && (sel == RSEL_STATUS);
    wr_hit.en_set = bus_sel && bus_we && (sel == RSEL_EN_SET);
    wr_hit.en_clr = bus_sel && bus_we && (sel == RSEL_EN_CLR);
    wr_hit.base   = bus_sel && bus_we && (sel == RSEL_BASE);
    wr_hit.size   = bus_sel && bus_we && (sel == RSEL_SIZE);
  end

  assign rd_en  = bus_sel && !bus_we;
  assign rd_sel = sel;
endmodule

// File: rtl/gfx_irq_bank.sv
module gfx_irq_bank #(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] raise,
  input  logic            ack_we,
  input  logic [NSRC-1:0] ack_bits,
  input  logic            set_we,
  input  logic            clr_we,
  input  logic [NSRC-1:0] mask_bits,
  output logic [NSRC-1:0] status_q,
  output logic [NSRC-1:0] mask_q,
  output logic            irq_q
);
  logic [NSRC-1:0] status_d;
  logic [NSRC-1:0] mask_d;

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    logic ack_i;
    logic en_up_i;
    logic en_dn_i;
    assign ack_i      = ack_we && ack_bits[i];
    assign en_up_i    = set_we && mask_bits[i];
    assign en_dn_i    = clr_we && mask_bits[i];
    assign status_d[i] = raise[i] | (status_q[i] & ~ack_i);
    assign mask_d[i]   = en_up_i | (mask_q[i] & ~en_dn_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      mask_q   <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_d;
      mask_q   <= mask_d;
      irq_q    <= |(status_q & mask_q);
    end
  end
endmodule

// File: rtl/gfx_oom_pool.sv
module gfx_oom_pool #(
  parameter int DATA_W  = 32,
  parameter int POOL_AW = 32,
  parameter int POOL_SW = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               base_we,
  input  logic               size_we,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               mem_req,
  input  logic               consume,
  output logic [POOL_AW-1:0] base_q,
  output logic [POOL_SW-1:0] size_q,
  output logic               cond_q
);
  logic [POOL_SW-1:0] size_d;
  logic               cond_d;

  always_comb begin
    if (size_we)      size_d = wdata[POOL_SW-1:0];
    else if (consume) size_d = '0;
    else              size_d = size_q;
    cond_d = (size_d == '0) && (cond_q || mem_req);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      size_q <= '0;
      cond_q <= 1'b0;
    end else begin
      if (base_we) base_q <= wdata[POOL_AW-1:0];
      size_q <= size_d;
      cond_q <= cond_d;
    end
  end
endmodule

// File: rtl/gfx_irq_ctrl.sv
module gfx_irq_ctrl
  import gfx_irq_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 32,
  parameter int POOL_AW = 32,
  parameter int POOL_SW = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_sel,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic               flush_done,
  input  logic               frame_done,
  input  logic               mem_req,
  input  logic               pool_consume,
  output logic [POOL_AW-1:0] pool_base,
  output logic [POOL_SW-1:0] pool_size,
  output logic               irq
);
  wr_hit_t          wr_hit;
  logic             rd_en;
  rsel_e            rd_sel;
  logic [SRC_N-1:0] raise;
  logic [SRC_N-1:0] status_q;
  logic [SRC_N-1:0] mask_q;
  logic             oom_cond;
  logic [DATA_W-1:0] rd_mux;

  gfx_irq_decode #(.ADDR_W(ADDR_W)) u_dec (
    .bus_sel (bus_sel),
    .bus_we  (bus_we),
    .bus_addr(bus_addr),
    .wr_hit  (wr_hit),
    .rd_en   (rd_en),
    .rd_sel  (rd_sel)
  );

  gfx_oom_pool #(.DATA_W(DATA_W), .POOL_AW(POOL_AW), .POOL_SW(POOL_SW)) u_pool (
    .clk    (clk),
    .rst    (rst),
    .base_we(wr_hit.base),
    .size_we(wr_hit.size),
    .wdata  (bus_wdata),
    .mem_req(mem_req),
    .consume(pool_consume),
    .base_q (pool_base),
    .size_q (pool_size),
    .cond_q (oom_cond)
  );

  always_comb begin
    raise            = '0;
    raise[SRC_FLUSH] = flush_done;
    raise[SRC_FRAME] = frame_done;
    raise[SRC_OOM]   = oom_cond;
  end

  gfx_irq_bank #(.NSRC(SRC_N)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .raise    (raise),
    .ack_we   (wr_hit.status),
    .ack_bits (bus_wdata[SRC_N-1:0]),
    .set_we   (wr_hit.en_set),
    .clr_we   (wr_hit.en_clr),
    .mask_bits(bus_wdata[SRC_N-1:0]),
    .status_q (status_q),
    .mask_q   (mask_q),
    .irq_q    (irq)
  );

  always_comb begin
    case (rd_sel)
      RSEL_STATUS: rd_mux = DATA_W'(status_q);
      RSEL_EN_SET,
      RSEL_EN_CLR: rd_mux = DATA_W'(mask_q);
      RSEL_BASE:   rd_mux = DATA_W'(pool_base);
      RSEL_SIZE:   rd_mux = DATA_W'(pool_size);
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        bus_rdata <= '0;
    else if (rd_en) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/gfx_irq_ctrl_chk.sv
module gfx_irq_ctrl_chk #(
  parameter int NSRC   = 3,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [NSRC-1:0]   st,
  input logic [NSRC-1:0]   en,
  input logic              irq,
  input logic              flush_evt,
  input logic              frame_evt,
  input logic              cond,
  input logic              st_wr,
  input logic              size_wr,
  input logic [DATA_W-1:0] wdata
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (st == '0 && en == '0 && !irq));

  // R2
  flush_latch_chk: assert property (@(posedge clk) disable iff (rst)
    flush_evt |=> st[0]);

  // R2
  frame_latch_chk: assert property (@(posedge clk) disable iff (rst)
    frame_evt |=> st[1]);

  // R3
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (st_wr && wdata[1] && !frame_evt) |=> !st[1]);

  // R4
  event_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (st_wr && wdata[0] && flush_evt) |=> st[0]);

  // R8
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq == $past(|(st & en))));

  // R9
  oom_persist_chk: assert property (@(posedge clk) disable iff (rst)
    cond |=> st[2]);

  // R10
  size_resolve_chk: assert property (@(posedge clk) disable iff (rst)
    (size_wr && wdata != '0) |=> !cond);
endmodule

bind gfx_irq_ctrl gfx_irq_ctrl_chk #(.NSRC(gfx_irq_pkg::SRC_N), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .st       (status_q),
  .en       (mask_q),
  .irq      (irq),
  .flush_evt(flush_done),
  .frame_evt(frame_done),
  .cond     (oom_cond),
  .st_wr    (wr_hit.status),
  .size_wr  (wr_hit.size),
  .wdata    (bus_wdata)
);

// File: tb/tb_gfx_irq_ctrl.sv
module tb_gfx_irq_ctrl;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        flush_done = 1'b0;
  logic        frame_done = 1'b0;
  logic        mem_req = 1'b0;
  logic        pool_consume = 1'b0;
  logic [31:0] pool_base;
  logic [31:0] pool_size;
  logic        irq;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  gfx_irq_ctrl dut (
    .clk(clk), .rst(rst),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .flush_done(flush_done), .frame_done(frame_done),
    .mem_req(mem_req), .pool_consume(pool_consume),
    .pool_base(pool_base), .pool_size(pool_size), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse_flush();
    @(negedge clk); flush_done = 1'b1;
    @(negedge clk); flush_done = 1'b0;
  endtask

  task automatic pulse_frame();
    @(negedge clk); frame_done = 1'b1;
    @(negedge clk); frame_done = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 pool_size", pool_size, 32'h0);
    check("R1 pool_base", pool_base, 32'h0);
    rd(5'h00, d); check("R1 status", d, 32'h0);
    rd(5'h04, d); check("R1 mask", d, 32'h0);
  endtask

  task automatic t_events();
    logic [31:0] d;
    pulse_flush();
    rd(5'h00, d); check("R2 flush bit0", d, 32'h1);
    check("R8 masked irq low", {31'b0, irq}, 32'h0);
    pulse_frame();
    rd(5'h00, d); check("R2 frame bit1", d, 32'h3);
    wr(5'h00, 32'h1);
    rd(5'h00, d); check("R3 partial ack", d, 32'h2);
    wr(5'h00, 32'h2);
    rd(5'h00, d); check("R3 full ack", d, 32'h0);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    wr(5'h04, 32'h1);
    rd(5'h04, d); check("R5 set bit0", d, 32'h1);
    rd(5'h08, d); check("R7 mask via clr reg", d, 32'h1);
    wr(5'h04, 32'h2);
    rd(5'h04, d); check("R5 zeros ignored", d, 32'h3);
    wr(5'h08, 32'h1);
    rd(5'h08, d); check("R6 clear bit0", d, 32'h2);
    pulse_frame();
    check("R8 irq one cycle late", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R8 irq raised", {31'b0, irq}, 32'h1);
    wr(5'h00, 32'h2);
    check("R8 irq after ack edge", {31'b0, irq}, 32'h1);
    @(negedge clk);
    check("R8 irq dropped", {31'b0, irq}, 32'h0);
    pulse_flush();
    @(negedge clk);
    check("R6 disabled source no irq", {31'b0, irq}, 32'h0);
    wr(5'h00, 32'h1);
    wr(5'h08, 32'h2);
    rd(5'h04, d); check("R6 mask empty", d, 32'h0);
  endtask

  task automatic t_race();
    logic [31:0] d;
    pulse_flush();
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 5'h00; bus_wdata = 32'h1;
    flush_done = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; flush_done = 1'b0;
    rd(5'h00, d); check("R4 event beats clear", d, 32'h1);
    wr(5'h00, 32'h1);
    rd(5'h00, d); check("R4 later clear", d, 32'h0);
  endtask

  task automatic t_oom();
    logic [31:0] d;
    wr(5'h04, 32'h4);
    @(negedge clk); mem_req = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rd(5'h00, d); check("R9 oom set", d, 32'h4);
    check("R9 irq high", {31'b0, irq}, 32'h1);
    wr(5'h00, 32'h4);
    rd(5'h00, d); check("R9 ack has no effect", d, 32'h4);
    wr(5'h0C, 32'h1000_0000);
    wr(5'h10, 32'h0004_0000);
    check("R10 pool_base port", pool_base, 32'h1000_0000);
    check("R10 pool_size port", pool_size, 32'h0004_0000);
    wr(5'h00, 32'h4);
    rd(5'h00, d); check("R10 ack clears", d, 32'h0);
    wr(5'h04, 32'h4);
    @(negedge clk);
    check("R10 irq stays low", {31'b0, irq}, 32'h0);
    rd(5'h0C, d); check("R10 base read", d, 32'h1000_0000);
    rd(5'h10, d); check("R10 size read", d, 32'h0004_0000);
    @(negedge clk); pool_consume = 1'b1;
    @(negedge clk); pool_consume = 1'b0;
    check("R11 size zero", pool_size, 32'h0);
    @(negedge clk);
    rd(5'h00, d); check("R11 oom again", d, 32'h4);
    mem_req = 1'b0;
    wr(5'h10, 32'h100);
    wr(5'h00, 32'h4);
    rd(5'h00, d); check("R11 cleanup", d, 32'h0);
    wr(5'h08, 32'h7);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(5'h04, 32'h3);
    wr(5'h14, 32'hFFFF_FFFF);
    rd(5'h14, d); check("R12 unmapped read", d, 32'h0);
    rd(5'h04, d); check("R12 mask untouched", d, 32'h3);
    rd(5'h10, d); check("R12 size untouched", d, 32'h100);
    rd(5'h00, d); check("R12 status untouched", d, 32'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_events();
    t_enable();
    t_race();
    t_oom();
    t_unmapped();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule